// File: doc/BRIEF.md
# EDID Read Controller with Register Interface

This block lets a host fetch a display's 128-byte identification table through four 32-bit registers: a port selector, a command register, a status register and a data register. The host picks a display connector, issues a read command aimed at the identification slave (7-bit address 0x50), and then drains the table by reading the data register, which hands back up to four bytes per access. No wires toggle; the block answers each transaction at register level and tracks a bus phase (idle, data, wait), a byte budget and a read pointer.

The table itself sits in an internal byte array filled through a side write port before use. Four per-connector presence flags say which connectors carry a monitor; a connector without one reports a slave timeout instead of data. Register reads return data one cycle after the request, flagged by a valid strobe.

Top module: `edid_reg_ctl`

## Requirements
- R1: After reset every register reads as zero and the bus phase output is idle (0 idle, 1 data, 2 wait).
- R2: Writing the port selector (address 0) clears transaction state and sets the phase idle; low bits 2, 4, 5, 6 pick connectors E, C, B, D, which are presence flags bits 3, 1, 0, 2. A valid pick sets status bits 11 and 14, clears bit 9, and clears bit 10 with the table enabled when the monitor is present, else sets bit 10; any other value leaves status untouched and the table disabled.
- R3: A command write (address 1) whose bits 27:25 are 1, 3, 5 or 7 moves the phase to data and sets status bit 9; bits 7:1 equal to 0x50 select the slave, bit 0 marks a read, bits 24:16 give the byte count and bit 26 loads the pointer from bits 15:8.
- R4: Command bit 30 is never kept in the stored command.
- R5: Cycle type 4 sets the phase idle, clears status bit 9 and resets transaction state, but only when the stored cycle type was nonzero.
- R6: Command bit 31 newly set clears status bit 12 and sets bit 11; while it is stored, a write with it set changes nothing, and a write with it clear only clears it, sets status to bit 11 alone plus bit 10 when the table is disabled, and sets the phase idle.
- R7: A data read (address 3) under a read command returns the next table bytes, lowest byte first, and advances the pointer.
- R8: When fewer than four bytes remain, only that many low bytes are replaced; the upper bytes keep the previous data value.
- R9: When four or fewer bytes remained, the phase becomes idle for cycle types 5 and 7 and wait otherwise, and transaction state is reset.
- R10: A data read with no bytes remaining returns the previous value unchanged.
- R11: A byte lane yields 0 without advancing the pointer when the slave is not selected, the pointer is at or past 128, or the table is disabled.
- R12: A status read (address 2) returns the value before the read and then sets bit 15; writing 1 to bit 15 clears it; all other status bits ignore writes.
- R13: Writes to the data register are ignored, and a data read without the read bit returns the stored value.
- R14: Read data is valid on the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 port, 1 command, 2 status, 3 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| mon_present | input | 4 | Monitor present per connector (B, C, D, E from bit 0) |
| edid_wr_en | input | 1 | Table load strobe |
| edid_wr_addr | input | 7 | Table load address |
| edid_wr_data | input | 8 | Table load byte |
| bus_phase | output | 2 | Current bus phase |

## Verification
The assertions assume a read and a write are never requested in the same cycle and that the presence flags stay still around a port-selector write; the bench drives exactly one strobe per access and changes no flag while it runs. They also take for granted that the table is loaded before any data read, which the bench does first. The stimulus walks each cycle type, the stop gating on the stored type, pointer overrun past the table end, short final reads and the clear-interrupt toggle.

// File: rtl/edid_ctl_pkg.sv
package edid_ctl_pkg;

    localparam int WORD_LANES = 4;
    localparam int PTR_W      = 9;
    localparam int CNT_W      = 9;

    localparam logic [1:0] A_PORT = 2'd0;
    localparam logic [1:0] A_CMD  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    localparam int ST_INUSE  = 15;
    localparam int ST_WAITPH = 14;
    localparam int ST_IRQ    = 12;
    localparam int ST_HWRDY  = 11;
    localparam int ST_TMO    = 10;
    localparam int ST_ACTIVE = 9;

    localparam int CM_CLRIRQ = 31;
    localparam int CM_SWRDY  = 30;
    localparam int CM_IDXEN  = 26;
    localparam int CM_DIR    = 0;

    localparam logic [2:0] CY_NONE = 3'd0;
    localparam logic [2:0] CY_STOP = 3'd4;
    localparam logic [6:0] TABLE_SLAVE = 7'h50;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic [31:0]      port_reg;
        logic [31:0]      cmd;
        logic [31:0]      data;
        logic [31:0]      rdata;
        logic             rvalid;
        logic             in_use;
        logic             wait_ph;
        logic             irq;
        logic             hw_rdy;
        logic             tmo;
        logic             active;
        logic             link_ok;
        logic             slave_ok;
        logic             avail;
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] total;
        logic [2:0]       txn_cyc;
        phase_e           phase;
    } ctl_t;

    function automatic logic [31:0] stat_word(input ctl_t s);
        logic [31:0] w;
        w            = '0;
        w[ST_INUSE]  = s.in_use;
        w[ST_WAITPH] = s.wait_ph;
        w[ST_IRQ]    = s.irq;
        w[ST_HWRDY]  = s.hw_rdy;
        w[ST_TMO]    = s.tmo;
        w[ST_ACTIVE] = s.active;
        return w;
    endfunction

    function automatic ctl_t txn_clear(input ctl_t s);
        ctl_t r;
        r          = s;
        r.link_ok  = 1'b0;
        r.slave_ok = 1'b0;
        r.avail    = 1'b0;
        r.ptr      = '0;
        r.total    = '0;
        r.txn_cyc  = CY_NONE;
        return r;
    endfunction

endpackage

// File: rtl/edid_byte_store.sv
module edid_byte_store #(
    parameter int DEPTH = 128,
    parameter int LANES = 4,
    parameter int PTR_W = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [PTR_W-1:0]   rd_base,
    output logic [LANES*8-1:0] rd_bytes
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PTR_W:0] lane_addr;
        assign lane_addr = {1'b0, rd_base} + (PTR_W+1)'(g);
        always_comb begin
            if (lane_addr < (PTR_W+1)'(DEPTH)) begin
                rd_bytes[g*8 +: 8] = mem_q[lane_addr[AW-1:0]];
            end else begin
                rd_bytes[g*8 +: 8] = 8'h00;
            end
        end
    end

endmodule

// File: rtl/edid_port_decode.sv
module edid_port_decode (
    input  logic [2:0] sel_code,
    output logic       sel_valid,
    output logic [1:0] sel_port
);

    // Connector order on the presence flags: B=0, C=1, D=2, E=3
    always_comb begin
        sel_valid = 1'b1;
        sel_port  = 2'd0;
        case (sel_code)
            3'd2:    sel_port = 2'd3;
            3'd4:    sel_port = 2'd1;
            3'd5:    sel_port = 2'd0;
            3'd6:    sel_port = 2'd2;
            default: sel_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/edid_lane_packer.sv
module edid_lane_packer #(
    parameter int DEPTH = 128,
    parameter int LANES = 4,
    parameter int PTR_W = 9,
    localparam int TW   = $clog2(LANES + 1)
) (
    input  logic               fetch_ok,
    input  logic [PTR_W-1:0]   base,
    input  logic [TW-1:0]      take,
    input  logic [LANES*8-1:0] lane_bytes,
    input  logic [LANES*8-1:0] old_word,
    output logic [LANES*8-1:0] new_word,
    output logic [TW-1:0]      advance
);

    logic [LANES-1:0] used_v;

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        logic           in_take;
        logic           in_range;
        logic [PTR_W:0] pos;
        assign pos      = {1'b0, base} + (PTR_W+1)'(g);
        assign in_take  = TW'(g) < take;
        assign in_range = pos < (PTR_W+1)'(DEPTH);
        assign used_v[g] = in_take && in_range && fetch_ok;
        always_comb begin
            if (!in_take) begin
                new_word[g*8 +: 8] = old_word[g*8 +: 8];
            end else if (used_v[g]) begin
                new_word[g*8 +: 8] = lane_bytes[g*8 +: 8];
            end else begin
                new_word[g*8 +: 8] = 8'h00;
            end
        end
    end

    assign advance = TW'($countones(used_v));

endmodule

// File: rtl/edid_reg_ctl.sv
module edid_reg_ctl
    import edid_ctl_pkg::*;
#(
    parameter int EDID_BYTES = 128,
    localparam int AW        = $clog2(EDID_BYTES),
    localparam int TW        = $clog2(WORD_LANES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic          reg_rd_en,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          reg_rvalid,
    input  logic [3:0]    mon_present,
    input  logic          edid_wr_en,
    input  logic [AW-1:0] edid_wr_addr,
    input  logic [7:0]    edid_wr_data,
    output logic [1:0]    bus_phase
);

    ctl_t q, d;

    logic                      dec_valid;
    logic [1:0]                dec_port;
    logic [WORD_LANES*8-1:0]   lane_bytes;
    logic [WORD_LANES*8-1:0]   packed_word;
    logic [TW-1:0]             adv;
    logic [TW-1:0]             take;
    logic signed [PTR_W+1:0]   left;
    logic                      fetch_ok;

    edid_port_decode i_dec (
        .sel_code  (reg_wdata[2:0]),
        .sel_valid (dec_valid),
        .sel_port  (dec_port)
    );

    edid_byte_store #(.DEPTH(EDID_BYTES), .LANES(WORD_LANES), .PTR_W(PTR_W)) i_store (
        .clk      (clk),
        .wr_en    (edid_wr_en),
        .wr_addr  (edid_wr_addr),
        .wr_data  (edid_wr_data),
        .rd_base  (q.ptr),
        .rd_bytes (lane_bytes)
    );

    assign left     = $signed({2'b00, q.total}) - $signed({2'b00, q.ptr});
    assign fetch_ok = q.link_ok && q.slave_ok && q.avail;

    always_comb begin
        if (left <= 0) begin
            take = '0;
        end else if (left >= (PTR_W+2)'(WORD_LANES)) begin
            take = TW'(WORD_LANES);
        end else begin
            take = TW'(left);
        end
    end

    edid_lane_packer #(.DEPTH(EDID_BYTES), .LANES(WORD_LANES), .PTR_W(PTR_W)) i_pack (
        .fetch_ok   (fetch_ok),
        .base       (q.ptr),
        .take       (take),
        .lane_bytes (lane_bytes),
        .old_word   (q.data),
        .new_word   (packed_word),
        .advance    (adv)
    );

    always_comb begin
        logic [31:0] cv;
        d        = q;
        d.rvalid = 1'b0;
        cv       = reg_wdata;
        cv[CM_SWRDY] = 1'b0;

        if (reg_wr_en) begin
            case (reg_addr)
                A_PORT: begin
                    d.port_reg = reg_wdata;
                    d          = txn_clear(d);
                    d.phase    = PH_IDLE;
                    if (dec_valid) begin
                        d.link_ok = 1'b1;
                        d.active  = 1'b0;
                        d.hw_rdy  = 1'b1;
                        d.wait_ph = 1'b1;
                        if (mon_present[dec_port]) begin
                            d.avail = 1'b1;
                            d.tmo   = 1'b0;
                        end else begin
                            d.tmo   = 1'b1;
                        end
                    end
                end
                A_CMD: begin
                    if (q.cmd[CM_CLRIRQ]) begin
                        if (!reg_wdata[CM_CLRIRQ]) begin
                            d.cmd[CM_CLRIRQ] = 1'b0;
                            d.in_use  = 1'b0;
                            d.wait_ph = 1'b0;
                            d.irq     = 1'b0;
                            d.hw_rdy  = 1'b1;
                            d.active  = 1'b0;
                            d.tmo     = !q.avail;
                            d.phase   = PH_IDLE;
                        end
                    end else begin
                        if (cv[CM_CLRIRQ]) begin
                            d.irq    = 1'b0;
                            d.hw_rdy = 1'b1;
                        end
                        d.total = cv[24:16];
                        if (cv[7:1] == TABLE_SLAVE) begin
                            d.slave_ok = 1'b1;
                        end
                        if (cv[CM_IDXEN]) begin
                            d.ptr = {1'b0, cv[15:8]};
                        end
                        d.txn_cyc = cv[27:25];
                        case (cv[27:25])
                            CY_STOP: begin
                                if (q.cmd[27:25] != CY_NONE) begin
                                    d        = txn_clear(d);
                                    d.phase  = PH_IDLE;
                                    d.active = 1'b0;
                                end
                            end
                            3'd1, 3'd3, 3'd5, 3'd7: begin
                                d.phase  = PH_DATA;
                                d.active = 1'b1;
                            end
                            default: ;
                        endcase
                        d.cmd = cv;
                    end
                end
                A_STAT: begin
                    if (reg_wdata[ST_INUSE]) begin
                        d.in_use = 1'b0;
                    end
                end
                default: ;
            endcase
        end else if (reg_rd_en) begin
            d.rvalid = 1'b1;
            case (reg_addr)
                A_PORT: d.rdata = q.port_reg;
                A_CMD:  d.rdata = q.cmd;
                A_STAT: begin
                    d.rdata  = stat_word(q);
                    d.in_use = 1'b1;
                end
                default: begin
                    d.rdata = q.data;
                    if (q.cmd[CM_DIR] && (left > 0)) begin
                        d.data  = packed_word;
                        d.rdata = packed_word;
                        d.ptr   = q.ptr + PTR_W'(adv);
                        if (left <= (PTR_W+2)'(WORD_LANES)) begin
                            if (q.txn_cyc == 3'd5 || q.txn_cyc == 3'd7) begin
                                d.phase = PH_IDLE;
                            end else begin
                                d.phase = PH_WAIT;
                            end
                            d = txn_clear(d);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign reg_rdata  = q.rdata;
    assign reg_rvalid = q.rvalid;
    assign bus_phase  = q.phase;

    // R14: read data strobe follows a lone read request by one cycle
    assert_rvalid_next_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en) |=> reg_rvalid);

    // R4: command readback never shows the software-ready bit
    assert_no_swrdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_addr == A_CMD) |=> !reg_rdata[CM_SWRDY]);

    // R3: data phase always comes with the active flag
    assert_data_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DATA) |-> q.active);

    // R12: status read leaves the in-use flag set
    assert_inuse_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_addr == A_STAT) |=> q.in_use);

    // R2: valid pick on an empty connector raises the timeout flag
    assert_nomon_tmo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_PORT && dec_valid && !mon_present[dec_port])
        |=> (q.tmo && !q.avail));

    // R11: pointer moves by at most one word per access
    assert_ptr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_addr == A_DATA && q.ptr < PTR_W'(EDID_BYTES))
        |=> (q.ptr <= $past(q.ptr) + PTR_W'(WORD_LANES) || q.ptr == '0));

endmodule

// File: tb/test_edid_reg_ctl.sv
module test_edid_reg_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [3:0]  mon_present = 4'b1011;
    logic        edid_wr_en = 1'b0;
    logic [6:0]  edid_wr_addr = '0;
    logic [7:0]  edid_wr_data = '0;
    logic [1:0]  bus_phase;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10ns clk = ~clk;

    edid_reg_ctl i_edid_reg_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_rd_en    (reg_rd_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .reg_rvalid   (reg_rvalid),
        .mon_present  (mon_present),
        .edid_wr_en   (edid_wr_en),
        .edid_wr_addr (edid_wr_addr),
        .edid_wr_data (edid_wr_data),
        .bus_phase    (bus_phase)
    );

    function automatic logic [7:0] tbl(input int i);
        return 8'(3 * i + 1);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic stat_chk(input logic [31:0] e, input string tag);
        wr(2'd2, 32'h0000_8000);
        rd(2'd2, e, tag);
    endtask

    task automatic ph_chk(input logic [1:0] e, input string tag);
        n_cmp++;
        if (bus_phase !== e) begin
            n_bad++;
            $display("FAIL %s: phase %0d expected %0d", tag, bus_phase, e);
        end
    endtask

    // monitor: pop expected values as read data appears
    always @(negedge clk) begin
        if (reg_rvalid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R14: unexpected read data %h expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: read %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 128; i++) begin
            edid_wr_en = 1'b1; edid_wr_addr = 7'(i); edid_wr_data = tbl(i);
            @(negedge clk);
        end
        edid_wr_en = 1'b0;

        // R1 reset state
        ph_chk(2'd0, "R1");
        rd(2'd0, 32'h0, "R1 port reg");
        rd(2'd1, 32'h0, "R1 command");
        rd(2'd2, 32'h0, "R1 status");
        rd(2'd2, 32'h0000_8000, "R12 in-use after read");
        wr(2'd2, 32'h0000_7FFF);
        rd(2'd2, 32'h0000_8000, "R12 read-only bits");
        wr(2'd2, 32'h0000_8000);
        rd(2'd2, 32'h0, "R12 in-use clear");
        wr(2'd3, 32'h1234_5678);
        rd(2'd3, 32'h0, "R13 data write ignored");

        // connector E, present
        wr(2'd0, 32'd2);
        stat_chk(32'h0000_4800, "R2 select E");
        wr(2'd1, 32'h4606_00A1);
        rd(2'd1, 32'h0606_00A1, "R4 strip sw-ready");
        ph_chk(2'd1, "R3 data phase");
        stat_chk(32'h0000_4A00, "R3 active set");
        rd(2'd3, {tbl(3), tbl(2), tbl(1), tbl(0)}, "R7 first word");
        ph_chk(2'd1, "R7 still data");
        rd(2'd3, {tbl(3), tbl(2), tbl(5), tbl(4)}, "R8 short word");
        ph_chk(2'd2, "R9 wait after non-stop");
        rd(2'd3, {tbl(3), tbl(2), tbl(5), tbl(4)}, "R10 nothing left");

        // stop with nonzero stored cycle
        wr(2'd1, 32'h0804_00A1);
        ph_chk(2'd0, "R5 stop idle");
        stat_chk(32'h0000_4800, "R5 active cleared");
        rd(2'd3, {tbl(3), tbl(2), tbl(5), tbl(4)}, "R5 state reset");

        // stop with zero stored cycle is ignored
        wr(2'd0, 32'd2);
        wr(2'd1, 32'h0004_00A1);
        wr(2'd1, 32'h0804_00A1);
        rd(2'd3, {tbl(3), tbl(2), tbl(1), tbl(0)}, "R5 stop ignored");
        ph_chk(2'd2, "R9 wait for type 4");

        // pointer overruns the table end
        wr(2'd0, 32'd2);
        wr(2'd1, 32'h0E82_7EA1);
        ph_chk(2'd1, "R3 type 7 data");
        rd(2'd3, {16'h0000, tbl(127), tbl(126)}, "R11 past end");
        ph_chk(2'd0, "R9 idle after stop type");

        // wrong slave
        wr(2'd0, 32'd2);
        wr(2'd1, 32'h0202_00A3);
        rd(2'd3, 32'h0, "R11 slave not selected");
        ph_chk(2'd2, "R9 wait type 1");

        // connector D, absent
        wr(2'd0, 32'd6);
        stat_chk(32'h0000_4C00, "R2 no monitor");
        wr(2'd1, 32'h0202_00A1);
        rd(2'd3, 32'h0, "R2 no table on absent");

        // invalid selector
        wr(2'd0, 32'd3);
        stat_chk(32'h0000_4E00, "R2 invalid leaves status");
        wr(2'd1, 32'h0202_00A1);
        rd(2'd3, 32'h0, "R2 invalid no table");

        // connector B
        wr(2'd0, 32'd5);
        stat_chk(32'h0000_4800, "R2 select B");
        wr(2'd1, 32'h0202_00A1);
        rd(2'd3, {16'h0000, tbl(1), tbl(0)}, "R2 B reads table");

        // clear-interrupt bit
        wr(2'd0, 32'd4);
        wr(2'd1, 32'h8202_00A1);
        rd(2'd1, 32'h8202_00A1, "R6 bit stored");
        ph_chk(2'd1, "R6 transfer applied");
        wr(2'd1, 32'h8E00_00A1);
        rd(2'd1, 32'h8202_00A1, "R6 write ignored while set");
        ph_chk(2'd1, "R6 phase kept");
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, 32'h0202_00A1, "R6 only bit cleared");
        ph_chk(2'd0, "R6 phase idle");
        rd(2'd2, 32'h0000_0800, "R6 status ready only");
        wr(2'd0, 32'd6);
        wr(2'd1, 32'h8000_0000);
        wr(2'd1, 32'h0000_0000);
        rd(2'd2, 32'h0000_0C00, "R6 timeout without table");

        repeat (4) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R14: %0d reads unanswered expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule